// File: doc/BRIEF.md
# Register Address Auto-Increment Sequencer

This block supplies the register address for a serial read port that returns registers one after another without a fresh command per register. When a read command begins, the block captures the requested start address. Each time the serial shifter reports that one full register has been transferred, the block moves the address to the next register.

How far the address may run before it wraps back is set by a 2-bit loop-mode input. The span can be the whole register map, the type block (data or control) that holds the current address, or the group that holds it. A fourth mode keeps the address fixed, so the same register is read repeatedly. The group and type boundaries are parameters, given as lists of lowest addresses. Each span ends one below the next span's lowest address, and the last span ends at the top of the map.

The controller is a two-state machine. SEQ_IDLE is the state after reset: the address is 0 and transfer strobes are ignored. SEQ_RUN is entered on any command start and stays active. The transitions are: IDLE to RUN on command start; RUN to RUN on command start, which reloads the address; RUN to RUN on a transfer strobe, which advances the address. With no event in either state, the state and the address stay where they are.

Top module: `regaddr_seq`

## Requirements
- R1: While reset is high, and afterwards until the first command start, `rd_addr` is 0. Any `reg_done` pulse seen in this period is ignored.
- R2: When `cmd_start` is high at a clock edge, `rd_addr` equals `start_addr` from the next cycle. This applies in either state, and a `reg_done` in the same cycle has no effect.
- R3: With `loop_mode` = 2'b11, each `reg_done` adds 1 to the address. After address 11 (0xB), the top of the map, the address returns to 0.
- R4: With `loop_mode` = 2'b10, the address wraps inside its type span, which is 0..5 (data) or 6..11 (control). So 5 goes to 0 and 11 goes to 6.
- R5: With `loop_mode` = 2'b01, the address wraps inside its group span, which is 0..5, 6..7 or 8..11. So 5 goes to 0, 7 goes to 6 and 11 goes to 8.
- R6: With `loop_mode` = 2'b00, a `reg_done` leaves the address unchanged.
- R7: The address changes only on a `reg_done` pulse, by one step per pulse. The step uses the `loop_mode` value present in that same cycle.
- R8: A start address above the top of the map (12..15) counts as lying in the last span. The next advance goes to 0 in mode 2'b11, to 6 in mode 2'b10 and to 8 in mode 2'b01. In mode 2'b00 the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_start | input | 1 | One-cycle pulse when a read command begins |
| start_addr | input | 4 | Address to load on `cmd_start` |
| reg_done | input | 1 | One-cycle pulse when a register transfer completes |
| loop_mode | input | 2 | 11 = whole map, 10 = type, 01 = group, 00 = hold |
| rd_addr | output | 4 | Current register address |

## Verification
The checker tests these properties on every cycle: the reload on a command start, the address staying still when no strobe arrives, holding in mode 00, the address staying inside the map after any advance from a legal address, the wrap from the map top to 0, and the zero address while idle. Wraps at the type and group boundaries, starts above the map, and mode changes between strobes can only be shown by the bench. The bench starts from every address in every mode and compares each step against its own reference model, then replays random mixes of commands, strobes and mode changes.

// File: rtl/regaddr_seq_pkg.sv
package regaddr_seq_pkg;

    typedef enum logic [1:0] {
        LOOP_HOLD  = 2'b00,
        LOOP_GROUP = 2'b01,
        LOOP_TYPE  = 2'b10,
        LOOP_MAP   = 2'b11
    } loop_mode_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/regaddr_range_find.sv
// Finds the contiguous span that contains an address, given a list of
// ascending span base addresses. The last span ends at the map top; any
// address above the map top falls in the last span.
module regaddr_range_find #(
    parameter int ADDR_W = 4,
    parameter int NUM    = 3,
    parameter int MAP_HI = 11,
    parameter logic [NUM*ADDR_W-1:0] LO_LIST = '0
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] span_lo,
    output logic [ADDR_W-1:0] span_hi
);

    localparam logic [ADDR_W-1:0] MAP_TOP = ADDR_W'(MAP_HI);

    logic [ADDR_W-1:0] lo_v [NUM];
    logic [ADDR_W-1:0] hi_v [NUM];
    logic [NUM-1:0]    hit;

    for (genvar g = 0; g < NUM; g++) begin : g_span
        assign lo_v[g] = LO_LIST[g*ADDR_W +: ADDR_W];
        if (g == NUM - 1) begin : g_last
            assign hi_v[g] = MAP_TOP;
        end else begin : g_mid
            assign hi_v[g] = LO_LIST[(g+1)*ADDR_W +: ADDR_W] - ADDR_W'(1);
        end
        assign hit[g] = (cur >= lo_v[g]);
    end

    // Highest matching base wins, since bases ascend.
    always_comb begin
        span_lo = lo_v[0];
        span_hi = hi_v[0];
        for (int i = 0; i < NUM; i++) begin
            if (hit[i]) begin
                span_lo = lo_v[i];
                span_hi = hi_v[i];
            end
        end
    end

endmodule

// File: rtl/regaddr_span_sel.sv
// Chooses the wrap span for the current address from the loop mode.
module regaddr_span_sel
    import regaddr_seq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int MAP_HI     = 11,
    parameter int NUM_GROUPS = 3,
    parameter int NUM_TYPES  = 2,
    parameter logic [NUM_GROUPS*ADDR_W-1:0] GROUP_LO_LIST = '0,
    parameter logic [NUM_TYPES*ADDR_W-1:0]  TYPE_LO_LIST  = '0
) (
    input  logic [ADDR_W-1:0] cur,
    input  loop_mode_e        mode,
    output logic [ADDR_W-1:0] span_lo,
    output logic [ADDR_W-1:0] span_hi,
    output logic              hold
);

    localparam logic [ADDR_W-1:0] MAP_TOP = ADDR_W'(MAP_HI);

    logic [ADDR_W-1:0] grp_lo, grp_hi, typ_lo, typ_hi;

    regaddr_range_find #(
        .ADDR_W (ADDR_W),
        .NUM    (NUM_GROUPS),
        .MAP_HI (MAP_HI),
        .LO_LIST(GROUP_LO_LIST)
    ) u_grp (
        .cur    (cur),
        .span_lo(grp_lo),
        .span_hi(grp_hi)
    );

    regaddr_range_find #(
        .ADDR_W (ADDR_W),
        .NUM    (NUM_TYPES),
        .MAP_HI (MAP_HI),
        .LO_LIST(TYPE_LO_LIST)
    ) u_typ (
        .cur    (cur),
        .span_lo(typ_lo),
        .span_hi(typ_hi)
    );

    always_comb begin
        span_lo = '0;
        span_hi = MAP_TOP;
        hold    = 1'b0;
        unique case (mode)
            LOOP_MAP: begin
                span_lo = '0;
                span_hi = MAP_TOP;
            end
            LOOP_TYPE: begin
                span_lo = typ_lo;
                span_hi = typ_hi;
            end
            LOOP_GROUP: begin
                span_lo = grp_lo;
                span_hi = grp_hi;
            end
            LOOP_HOLD: begin
                hold = 1'b1;
            end
            default: hold = 1'b1;
        endcase
    end

endmodule

// File: rtl/regaddr_stepper.sv
// One advance step: wrap to the span base once the span top is reached
// or passed, otherwise add one.
module regaddr_stepper #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] span_lo,
    input  logic [ADDR_W-1:0] span_hi,
    input  logic              hold,
    output logic [ADDR_W-1:0] nxt
);

    always_comb begin
        if (hold) begin
            nxt = cur;
        end else if (cur >= span_hi) begin
            nxt = span_lo;
        end else begin
            nxt = cur + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/regaddr_seq.sv
module regaddr_seq
    import regaddr_seq_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int MAP_HI     = 11,
    parameter int NUM_GROUPS = 3,
    parameter int NUM_TYPES  = 2,
    parameter logic [NUM_GROUPS*ADDR_W-1:0] GROUP_LO_LIST = {4'd8, 4'd6, 4'd0},
    parameter logic [NUM_TYPES*ADDR_W-1:0]  TYPE_LO_LIST  = {4'd6, 4'd0}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              reg_done,
    input  logic [1:0]        loop_mode,
    output logic [ADDR_W-1:0] rd_addr
);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [ADDR_W-1:0] span_lo, span_hi, step_addr;
    logic              span_hold;

    regaddr_span_sel #(
        .ADDR_W       (ADDR_W),
        .MAP_HI       (MAP_HI),
        .NUM_GROUPS   (NUM_GROUPS),
        .NUM_TYPES    (NUM_TYPES),
        .GROUP_LO_LIST(GROUP_LO_LIST),
        .TYPE_LO_LIST (TYPE_LO_LIST)
    ) u_span (
        .cur    (addr_q),
        .mode   (loop_mode_e'(loop_mode)),
        .span_lo(span_lo),
        .span_hi(span_hi),
        .hold   (span_hold)
    );

    regaddr_stepper #(
        .ADDR_W(ADDR_W)
    ) u_step (
        .cur    (addr_q),
        .span_lo(span_lo),
        .span_hi(span_hi),
        .hold   (span_hold),
        .nxt    (step_addr)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and address selection
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (cmd_start) begin
                    state_d = SEQ_RUN;
                    addr_d  = start_addr;
                end
            end
            SEQ_RUN: begin
                if (cmd_start) begin
                    addr_d = start_addr;
                end else if (reg_done) begin
                    addr_d = step_addr;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign rd_addr = addr_q;

endmodule

// File: rtl/regaddr_seq_chk.sv
module regaddr_seq_chk #(
    parameter int ADDR_W = 4,
    parameter int MAP_HI = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              reg_done,
    input logic [1:0]        loop_mode,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              seq_run
);

    localparam logic [ADDR_W-1:0] MAP_TOP = ADDR_W'(MAP_HI);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (!seq_run && !cmd_start) |=> (rd_addr == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (rd_addr == $past(start_addr)));

    p_map_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_run && !cmd_start && reg_done && loop_mode == 2'b11 && rd_addr == MAP_TOP)
        |=> (rd_addr == '0));

    p_in_map_r3: assert property (@(posedge clk) disable iff (rst)
        (seq_run && !cmd_start && reg_done && loop_mode != 2'b00 && rd_addr <= MAP_TOP)
        |=> (rd_addr <= MAP_TOP));

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cmd_start && reg_done && loop_mode == 2'b00) |=> $stable(rd_addr));

    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!cmd_start && !reg_done) |=> $stable(rd_addr));

endmodule

bind regaddr_seq regaddr_seq_chk #(
    .ADDR_W(ADDR_W),
    .MAP_HI(MAP_HI)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_start (cmd_start),
    .start_addr(start_addr),
    .reg_done  (reg_done),
    .loop_mode (loop_mode),
    .rd_addr   (rd_addr),
    .seq_run   (state_q == regaddr_seq_pkg::SEQ_RUN)
);

// File: tb/regaddr_seq_tb.sv
module regaddr_seq_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_start;
    logic [3:0] start_addr;
    logic       reg_done;
    logic [1:0] loop_mode;
    logic [3:0] rd_addr;

    int checks = 0;
    int errors = 0;

    logic       m_run;
    logic [3:0] m_addr;

    always #4 clk = ~clk;

    regaddr_seq u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .start_addr(start_addr),
        .reg_done  (reg_done),
        .loop_mode (loop_mode),
        .rd_addr   (rd_addr)
    );

    // Reference step from the requirements: map 0..11, types 0..5/6..11,
    // groups 0..5/6..7/8..11, addresses above 11 sit in the last span.
    function automatic logic [3:0] ref_next(input logic [3:0] a, input logic [1:0] m);
        int lo, hi;
        if (m == 2'b00) return a;
        if (m == 2'b11) begin
            lo = 0; hi = 11;
        end else if (m == 2'b10) begin
            if (a < 6) begin lo = 0; hi = 5; end
            else begin lo = 6; hi = 11; end
        end else begin
            if (a < 6) begin lo = 0; hi = 5; end
            else if (a < 8) begin lo = 6; hi = 7; end
            else begin lo = 8; hi = 11; end
        end
        if (int'(a) >= hi) return 4'(lo);
        return a + 4'd1;
    endfunction

    function automatic string mode_tag(input logic [1:0] m, input logic [3:0] a);
        if (a > 4'd11 && m != 2'b00) return "R8";
        case (m)
            2'b11:   return "R3";
            2'b10:   return "R4";
            2'b01:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (rd_addr !== exp) begin
            errors++;
            $display("FAIL %s rd_addr actual %0d expected %0d", tag, rd_addr, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update model, sample after the rise.
    task automatic step(input logic cs, input logic [3:0] sa, input logic dn,
                        input logic [1:0] m, input string tag);
        string t;
        @(negedge clk);
        cmd_start  = cs;
        start_addr = sa;
        reg_done   = dn;
        loop_mode  = m;
        t = tag;
        if (cs) begin
            m_addr = sa;
            m_run  = 1'b1;
        end else if (m_run && dn) begin
            if (t == "") t = mode_tag(m, m_addr);
            m_addr = ref_next(m_addr, m);
        end
        if (t == "") t = "R7";
        @(posedge clk);
        #1;
        check(t, m_addr);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; cmd_start = 1'b0; start_addr = '0; reg_done = 1'b0; loop_mode = 2'b10;
        m_run = 1'b0; m_addr = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", 4'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1: strobes before any command are ignored
        for (int i = 0; i < 4; i++) step(1'b0, 4'd7, 1'b1, 2'(i), "R1");

        // R2: load with a same-cycle strobe present
        step(1'b1, 4'd9, 1'b1, 2'b11, "R2");
        step(1'b1, 4'd3, 1'b0, 2'b11, "R2");

        // Every start address in every mode, 14 strobes each
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < 16; a++) begin
                step(1'b1, 4'(a), 1'b0, 2'(m), "R2");
                for (int k = 0; k < 14; k++) step(1'b0, 4'(a), 1'b1, 2'(m), "");
            end
        end

        // Directed wrap corners
        step(1'b1, 4'd11, 1'b0, 2'b11, "R2"); step(1'b0, 4'd0, 1'b1, 2'b11, "R3");
        step(1'b1, 4'd5,  1'b0, 2'b10, "R2"); step(1'b0, 4'd0, 1'b1, 2'b10, "R4");
        step(1'b1, 4'd7,  1'b0, 2'b01, "R2"); step(1'b0, 4'd0, 1'b1, 2'b01, "R5");
        step(1'b1, 4'd13, 1'b0, 2'b01, "R2"); step(1'b0, 4'd0, 1'b1, 2'b01, "R8");

        // R7: mode change between strobes applies at the next strobe only
        step(1'b1, 4'd6, 1'b0, 2'b11, "R2");
        step(1'b0, 4'd0, 1'b0, 2'b01, "R7");
        step(1'b0, 4'd0, 1'b1, 2'b01, "R7");
        step(1'b0, 4'd0, 1'b0, 2'b11, "R7");
        step(1'b0, 4'd0, 1'b1, 2'b01, "R5");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            logic       cs, dn;
            logic [3:0] sa;
            logic [1:0] m;
            cs = ($urandom % 10) == 0;
            dn = ($urandom % 3) != 0;
            sa = 4'($urandom);
            m  = 2'($urandom);
            step(cs, sa, dn, m, cs ? "R2" : "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule